// File: doc/BRIEF.md
# Stuck-at fault coverage engine for a six-gate NAND circuit

The block holds a small combinational test circuit: five primary inputs x1..x5, two outputs Y1 and Y2, and six two-input NAND gates. It builds this circuit twice. One copy stays fault-free. The other copy can have one stuck-at fault forced onto any primary input, any single gate input pin, or any gate output. A gate input pin is a fault site of its own, separate from the net that drives it. For the vector on the input port, the block compares the outputs of the two copies. If they differ on either output, the vector fails for that fault.

The block has two ways to apply a fault. In manual mode, software or a bench drives a fault code onto the injection port and reads the pass/fail flag directly. In sweep mode, a start strobe captures the vector and then applies every fault in turn, one per clock cycle. Each fault that the vector exposes sets its bit in a detected bitmap. The bitmap keeps its bits across sweeps until a clear strobe. The population count of the bitmap is the number of detected faults. Fault coverage is that count divided by the 46 faults.

Top module: `fcov_engine`

## Requirements
- R1: The fault-free outputs are given by g1=NAND(x1,x3), g2=NAND(x3,x4), g3=NAND(x2,g2), g4=NAND(g2,x5), Y1=g5=NAND(g1,g3) and Y2=g6=NAND(g3,g4). The vector port carries x1 in bit 4 down to x5 in bit 0. Output bit 0 is Y1 and output bit 1 is Y2.
- R2: Fault code bit 0 is the stuck value. Code bits 5:1 give the site number:
  - sites 0..4 are x1..x5;
  - site 5+2*(g-1)+p is input pin p of gate g, where p=0 is the first operand as listed in R1;
  - sites 17..22 are the outputs of g1..g6.

  Codes 46..63 inject nothing.
- R3: A fault on a primary input acts on every gate that input feeds. A fault on a gate input pin acts only on that pin. For example, with x3=0, a stuck fault on the first pin of g1 is masked and the vector passes.
- R4: The fail flag is high exactly when the faulty copy's outputs differ from the fault-free outputs on at least one bit. When injection is disabled and no sweep is running, the flag is low.
- R5: While the block is idle, a start strobe captures the vector. The block then evaluates fault codes 0..45 in order, one per cycle, and stays busy for exactly 46 cycles. A start during a sweep, and any change of the vector port during a sweep, have no effect on that sweep.
- R6: The done flag rises in the cycle after the last fault is evaluated. A new start or a clear drops it.
- R7: During a sweep, bit f of the detected bitmap is set when fault code f makes the captured vector fail. Bits are never cleared except by the clear strobe, so detection accumulates over vectors.
- R8: The detected count always equals the number of set bits in the bitmap.
- R9: The clear strobe empties the bitmap on the next edge. It takes priority over a detection in the same cycle.
- R10: After reset the block is idle, done is low, and the bitmap and count are zero.
- R11: Vector 11101 (x1..x5) exposes x4 stuck-at-1 (code 7). Vector 11011 exposes the first pin of g2 stuck-at-1 (code 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_i | input | 5 | Test vector, x1 in bit 4 |
| inj_en_i | input | 1 | Enable manual fault injection |
| inj_code_i | input | 6 | Manual fault code |
| start_i | input | 1 | Start a sweep over all faults |
| clr_i | input | 1 | Clear the detected bitmap and done |
| y_good_o | output | 2 | Fault-free outputs {Y2,Y1} |
| y_fault_o | output | 2 | Faulty-copy outputs {Y2,Y1} |
| fail_o | output | 1 | Outputs of the two copies differ |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Last sweep completed |
| det_map_o | output | 46 | Detected-fault bitmap |
| det_cnt_o | output | 6 | Number of detected faults |

## Verification
The assertions check the following on every cycle:
- the bitmap only grows between clears, and a clear empties it;
- the count matches the bitmap;
- a start from idle raises busy;
- the end of a sweep raises done;
- with no fault applied, the fail flag stays low.

Only the bench's scenarios can show the rest. These are the netlist function, the fault-site numbering, and the difference between a stem fault and a pin fault. The bench compares all 32 vectors against all 64 codes with its own model of the circuit. It also checks the exact 46-cycle sweep length, that a start or a vector change during a sweep has no effect, and the bitmap accumulated over a sequence of vectors.

// File: rtl/fcov_pkg.sv
package fcov_pkg;
  localparam int NPI    = 5;
  localparam int NGATE  = 6;
  localparam int NNODE  = NPI + NGATE;
  localparam int NSITE  = NPI + 3 * NGATE;
  localparam int NFAULT = 2 * NSITE;
  localparam int CODE_W = $clog2(NFAULT);
  localparam int SITE_W = CODE_W - 1;
  localparam int CNT_W  = $clog2(NFAULT + 1);
  localparam int NOUT   = 2;

  // node numbering: 0..NPI-1 primary inputs, NPI+g gate g output
  function automatic int src_a(int g);
    case (g)
      0: return 0;
      1: return 2;
      2: return 1;
      3: return NPI + 1;
      4: return NPI + 0;
      default: return NPI + 2;
    endcase
  endfunction

  function automatic int src_b(int g);
    case (g)
      0: return 2;
      1: return 3;
      2: return NPI + 1;
      3: return 4;
      4: return NPI + 2;
      default: return NPI + 3;
    endcase
  endfunction

  function automatic int pin_site(int g, int p);
    return NPI + 2 * g + p;
  endfunction

  function automatic int out_site(int g);
    return NPI + 2 * NGATE + g;
  endfunction
endpackage

// File: rtl/fcov_netlist.sv
module fcov_netlist
  import fcov_pkg::*;
(
  input  logic [NPI-1:0]    x_i,
  input  logic              flt_en_i,
  input  logic [CODE_W-1:0] flt_code_i,
  output logic [NOUT-1:0]   y_o
);
  logic [SITE_W-1:0] site;
  logic              sv;
  logic [NSITE-1:0]  hit;
  logic [NNODE-1:0]  node;

  assign site = flt_code_i[CODE_W-1:1];
  assign sv   = flt_code_i[0];

  for (genvar s = 0; s < NSITE; s++) begin : g_dec
    assign hit[s] = flt_en_i && (site == SITE_W'(s));
  end

  always_comb begin
    logic a, b, o;
    node = '0;
    for (int i = 0; i < NPI; i++) begin
      node[i] = hit[i] ? sv : x_i[NPI-1-i];
    end
    // gates in topological order
    for (int g = 0; g < NGATE; g++) begin
      a = hit[pin_site(g, 0)] ? sv : node[src_a(g)];
      b = hit[pin_site(g, 1)] ? sv : node[src_b(g)];
      o = ~(a & b);
      node[NPI+g] = hit[out_site(g)] ? sv : o;
    end
  end

  assign y_o = {node[NNODE-1], node[NNODE-2]};
endmodule

// File: rtl/fcov_sweep.sv
module fcov_sweep
  import fcov_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clr_i,
  input  logic [NPI-1:0]    vec_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic [NPI-1:0]    vec_o
);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(NFAULT - 1);

  logic              busy_q, done_q;
  logic [CODE_W-1:0] code_q;
  logic [NPI-1:0]    vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      code_q <= '0;
      vec_q  <= '0;
    end else begin
      if (!busy_q && start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        code_q <= '0;
        vec_q  <= vec_i;
      end else if (busy_q) begin
        if (code_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          code_q <= code_q + 1'b1;
        end
      end
      if (clr_i) done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign code_o = code_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/fcov_bitmap.sv
module fcov_bitmap
  import fcov_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              set_en_i,
  input  logic [CODE_W-1:0] set_idx_i,
  input  logic              hit_i,
  output logic [NFAULT-1:0] map_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [NFAULT-1:0] map_q;

  for (genvar f = 0; f < NFAULT; f++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      map_q[f] <= 1'b0;
      else if (clr_i)   map_q[f] <= 1'b0;
      else if (set_en_i && hit_i && set_idx_i == CODE_W'(f))
        map_q[f] <= 1'b1;
    end
  end

  always_comb begin
    cnt_o = '0;
    for (int f = 0; f < NFAULT; f++) cnt_o = cnt_o + CNT_W'(map_q[f]);
  end

  assign map_o = map_q;
endmodule

// File: rtl/fcov_engine.sv
module fcov_engine
  import fcov_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPI-1:0]    vec_i,
  input  logic              inj_en_i,
  input  logic [CODE_W-1:0] inj_code_i,
  input  logic              start_i,
  input  logic              clr_i,
  output logic [NOUT-1:0]   y_good_o,
  output logic [NOUT-1:0]   y_fault_o,
  output logic              fail_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [NFAULT-1:0] det_map_o,
  output logic [CNT_W-1:0]  det_cnt_o
);
  logic              busy, done;
  logic [CODE_W-1:0] sw_code, flt_code;
  logic [NPI-1:0]    sw_vec, eval_vec;
  logic              flt_en;

  fcov_sweep i_sweep (
    .clk_i, .rst_ni, .start_i, .clr_i, .vec_i,
    .busy_o(busy), .done_o(done), .code_o(sw_code), .vec_o(sw_vec)
  );

  assign eval_vec = busy ? sw_vec  : vec_i;
  assign flt_code = busy ? sw_code : inj_code_i;
  assign flt_en   = busy | inj_en_i;

  fcov_netlist i_good (
    .x_i(eval_vec), .flt_en_i(1'b0), .flt_code_i('0), .y_o(y_good_o)
  );

  fcov_netlist i_bad (
    .x_i(eval_vec), .flt_en_i(flt_en), .flt_code_i(flt_code), .y_o(y_fault_o)
  );

  assign fail_o = |(y_good_o ^ y_fault_o);

  fcov_bitmap i_map (
    .clk_i, .rst_ni, .clr_i,
    .set_en_i(busy), .set_idx_i(sw_code), .hit_i(fail_o),
    .map_o(det_map_o), .cnt_o(det_cnt_o)
  );

  assign busy_o = busy;
  assign done_o = done;
endmodule

// File: rtl/fcov_checker.sv
module fcov_checker
  import fcov_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inj_en_i,
  input logic              start_i,
  input logic              clr_i,
  input logic              fail_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [NFAULT-1:0] det_map_o,
  input logic [CNT_W-1:0]  det_cnt_o
);
  a_r4_no_fault_no_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inj_en_i && !busy_o) |-> !fail_o);

  a_r5_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  a_r6_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(clr_i)) |-> done_o);

  a_r7_bits_only_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(det_map_o) & ~det_map_o) == '0));

  a_r7_count_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> det_cnt_o >= $past(det_cnt_o));

  a_r8_count_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_cnt_o == CNT_W'($countones(det_map_o)));

  a_r9_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (det_map_o == '0 && !done_o));
endmodule

bind fcov_engine fcov_checker i_chk (
  .clk_i, .rst_ni, .inj_en_i, .start_i, .clr_i,
  .fail_o, .busy_o, .done_o, .det_map_o, .det_cnt_o
);

// File: tb/test_fcov_engine.sv
module test_fcov_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  vec_i = '0;
  logic        inj_en_i = 1'b0;
  logic [5:0]  inj_code_i = '0;
  logic        start_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [1:0]  y_good_o, y_fault_o;
  logic        fail_o, busy_o, done_o;
  logic [45:0] det_map_o;
  logic [5:0]  det_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  fcov_engine i_fcov_engine (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic fz(logic v, int site, int s, logic sv);
    return (site == s) ? sv : v;
  endfunction

  // returns {Y2,Y1}
  function automatic logic [1:0] ref_y(logic [4:0] v, logic en, int code);
    int s;
    logic sv, x1, x2, x3, x4, x5, g1, g2, g3, g4, g5, g6;
    s  = (en && code < 46) ? code / 2 : -1;
    sv = code[0];
    x1 = fz(v[4], 0, s, sv); x2 = fz(v[3], 1, s, sv); x3 = fz(v[2], 2, s, sv);
    x4 = fz(v[1], 3, s, sv); x5 = fz(v[0], 4, s, sv);
    g1 = fz(~(fz(x1, 5, s, sv) & fz(x3, 6, s, sv)), 17, s, sv);
    g2 = fz(~(fz(x3, 7, s, sv) & fz(x4, 8, s, sv)), 18, s, sv);
    g3 = fz(~(fz(x2, 9, s, sv) & fz(g2, 10, s, sv)), 19, s, sv);
    g4 = fz(~(fz(g2, 11, s, sv) & fz(x5, 12, s, sv)), 20, s, sv);
    g5 = fz(~(fz(g1, 13, s, sv) & fz(g3, 14, s, sv)), 21, s, sv);
    g6 = fz(~(fz(g3, 15, s, sv) & fz(g4, 16, s, sv)), 22, s, sv);
    return {g6, g5};
  endfunction

  function automatic logic [45:0] ref_det(logic [4:0] v);
    logic [45:0] m = '0;
    for (int f = 0; f < 46; f++) m[f] = (ref_y(v, 1'b1, f) != ref_y(v, 1'b0, 0));
    return m;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [45:0] exp_map = '0;

  task automatic sweep(logic [4:0] v, bit disturb);
    int busy_cnt = 0;
    @(negedge clk_i);
    vec_i = v; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R5 busy after start", busy_o, 1);
    while (busy_o && busy_cnt < 200) begin
      busy_cnt++;
      if (disturb && busy_cnt == 10) begin
        vec_i = ~v; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    exp_map |= ref_det(v);
    chk(busy_cnt == 46, "R5 sweep length", busy_cnt, 46);
    chk(done_o, "R6 done after sweep", done_o, 1);
    chk(det_map_o == exp_map, "R7 bitmap", det_map_o, exp_map);
    chk(det_cnt_o == $countones(exp_map), "R8 count", det_cnt_o, $countones(exp_map));
  endtask

  initial begin
    #5;
    chk(!busy_o && !done_o && det_cnt_o == 0 && det_map_o == 0, "R10 reset state",
        {busy_o, done_o, det_cnt_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && det_cnt_o == 0, "R10 after release", det_cnt_o, 0);

    // manual mode, all vectors against all codes
    for (int v = 0; v < 32; v++) begin
      inj_en_i = 1'b0; vec_i = 5'(v);
      #2;
      chk(y_good_o == ref_y(5'(v), 1'b0, 0), "R1 good outputs", y_good_o, ref_y(5'(v), 1'b0, 0));
      chk(!fail_o, "R4 no injection", fail_o, 0);
      inj_en_i = 1'b1;
      for (int c = 0; c < 64; c++) begin
        logic [1:0] ey;
        inj_code_i = 6'(c);
        #2;
        ey = ref_y(5'(v), 1'b1, c);
        chk(y_fault_o == ey, "R2 R3 faulty outputs", y_fault_o, ey);
        chk(fail_o == (ey != ref_y(5'(v), 1'b0, 0)), "R4 fail flag", fail_o, ey != ref_y(5'(v), 1'b0, 0));
      end
    end

    vec_i = 5'b11101; inj_code_i = 6'd7; #2;
    chk(fail_o, "R11 x4 sa1 on 11101", fail_o, 1);
    vec_i = 5'b11011; inj_code_i = 6'd15; #2;
    chk(fail_o, "R11 g2 pin0 sa1 on 11011", fail_o, 1);
    vec_i = 5'b10011;
    for (int c = 10; c < 12; c++) begin
      inj_code_i = 6'(c); #2;
      chk(!fail_o, "R3 masked pin of g1", fail_o, 0);
    end
    inj_code_i = 6'd50; #2;
    chk(!fail_o, "R2 unused code", fail_o, 0);
    inj_en_i = 1'b0;

    // sweeps
    sweep(5'b11101, 1'b0);
    chk(det_map_o[7], "R11 sweep detects code 7", det_map_o[7], 1);
    sweep(5'b11011, 1'b1);
    chk(det_map_o[15], "R11 sweep detects code 15", det_map_o[15], 1);
    sweep(5'b00000, 1'b0);
    sweep(5'b10111, 1'b1);

    @(negedge clk_i); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
    exp_map = '0;
    chk(det_map_o == 0 && det_cnt_o == 0, "R9 clear", det_cnt_o, 0);
    chk(!done_o, "R6 clear drops done", done_o, 0);

    // clear during a sweep wins over detection
    @(negedge clk_i); vec_i = 5'b01010; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (45) @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
    chk(det_map_o == 0 && !done_o, "R9 clear priority", det_map_o, 0);

    for (int v = 0; v < 32; v++) sweep(5'(v), 1'b0);
    chk(det_cnt_o == $countones(exp_map), "R8 full coverage", det_cnt_o, $countones(exp_map));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule